// File: doc/BRIEF.md
# Fully Associative Data Translation Buffer

This block translates 32-bit effective addresses into physical addresses for a load/store path. It keeps a small set of page mappings, compares all of them at once against each lookup, and in the same cycle returns either a translated address, a miss, or an error. An error means the protection-group map denies the access, or a write has reached a page whose change bit is still clear. Software handles the error by marking the page modified and refilling the entry.

There is no hardware table walker. On a miss the block raises a flag and keeps it raised until software writes a new mapping through the refill port. Software keeps mappings current through two maintenance commands. One drops every entry whose upper address bits match a supplied address. The other drops every entry.

A small state machine tracks the outstanding-miss condition. It has two states. `ST_RUN` means no miss is outstanding. `ST_AWAIT_FILL` means a miss has been reported and no refill has been accepted since. A lookup miss is the transition into `ST_AWAIT_FILL`, taken from either state. An accepted refill in a cycle with no lookup miss is the transition back to `ST_RUN`.

Top module: `dtlb_fa`

## Requirements
- R1: Eight entries are compared in parallel. A lookup (`lk_req`=1) hits an entry when the entry is valid, its stored page tag equals `lk_ea[31:12]`, and its address-space tag matches. In that same cycle `lk_pa` = {stored 20-bit frame, `lk_ea[11:0]`}. `lk_pa` is zero when `lk_hit` is low.
- R2: An entry whose 4-bit address-space tag differs from `lk_asid` never matches, unless the entry was written with its shared flag set.
- R3: `lk_miss` is asserted when no entry matches. At most one of `lk_hit`, `lk_miss`, `lk_err` is high, and all three are low when `lk_req` is low.
- R4: A refill writes the lowest-numbered invalid slot. If no slot is invalid, it writes the slot named by a victim pointer. The pointer is 0 after reset and advances by one on every accepted refill, wrapping from 7 to 0.
- R5: `inv_one` clears every entry whose stored `ea[31:10]` (taken from `fill_ea`) equals `inv_ea[31:10]`, whatever its address-space tag. `inv_ea[9:0]` is ignored.
- R6: `inv_all` clears every entry in one cycle. From the next cycle no lookup hits or errors until a new refill.
- R7: When `inv_one` or `inv_all` is high, a refill in the same cycle is dropped and the victim pointer does not advance.
- R8: A matching write (`lk_write`=1) to an entry with its change bit clear asserts `lk_err` and not `lk_hit`. A read of that entry hits.
- R9: `map_we` loads the 32-bit group map. Group g uses bits [2g+1:2g], where 00 = no access, 01 = check page permission, 10 and 11 = full access. After reset every group holds 01. A matching access in a no-access group asserts `lk_err`.
- R10: In a check group, a matching write to an entry whose page-write bit is clear asserts `lk_err`. In a full-access group the page-write bit is ignored, but the change-bit rule of R8 still applies.
- R11: `refill_pending` is 1 in `ST_AWAIT_FILL`. The cycle after a lookup miss it is 1. The cycle after an accepted refill with no lookup miss it is 0.
- R12: After reset all entries are invalid and `refill_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_asid | input | 4 | Lookup address-space tag |
| lk_write | input | 1 | Lookup is a write |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No entry matched |
| lk_err | output | 1 | Entry matched but access refused |
| lk_pa | output | 32 | Translated physical address |
| fill_en | input | 1 | Refill write strobe |
| fill_ea | input | 32 | Effective address of the new mapping |
| fill_asid | input | 4 | Address-space tag of the new mapping |
| fill_shared | input | 1 | Mapping matches any address-space tag |
| fill_grp | input | 4 | Protection group index |
| fill_ppn | input | 20 | Physical frame number |
| fill_page_wr | input | 1 | Page-level write permission |
| fill_dirty | input | 1 | Change bit |
| inv_one | input | 1 | Invalidate entries matching `inv_ea[31:10]` |
| inv_all | input | 1 | Invalidate every entry |
| inv_ea | input | 32 | Address for single invalidation |
| map_we | input | 1 | Group map write strobe |
| map_wdata | input | 32 | Group map value |
| refill_pending | output | 1 | A miss awaits refill |

## Verification
Maintenance and refill can arrive in the same cycle. This collision decides both the entry contents and where the victim pointer stands. The bench provokes it on purpose: its random refills of a page already present also assert `inv_one` on that page. Directed steps add a refill with `inv_all` and a same-cycle refill plus lookup miss. A bench reference model judges each case by dropping the refill, holding the pointer, and then checking later lookups of the dropped address and the slot each following refill lands in.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_OFF = 12;
    localparam int VPN_W  = VA_W - PG_OFF;
    localparam int INV_W  = 22;
    localparam int PPN_W  = 20;
    localparam int ASID_W = 4;
    localparam int GRP_W  = 4;
    localparam int GROUPS = 2 ** GRP_W;
    localparam int MAP_W  = 2 * GROUPS;

    typedef struct packed {
        logic              valid;
        logic [INV_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic [GRP_W-1:0]  grp;
        logic [PPN_W-1:0]  ppn;
        logic              page_wr;
        logic              dirty;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        GA_NONE  = 2'b00,
        GA_PAGE  = 2'b01,
        GA_FULL  = 2'b10,
        GA_FULLX = 2'b11
    } grp_mode_e;

    typedef enum logic {
        ST_RUN        = 1'b0,
        ST_AWAIT_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_go,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_ent_t             wr_ent,
    input  logic                 inv_all,
    input  logic                 inv_one,
    input  logic [INV_W-1:0]     inv_tag,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic [ENTRIES-1:0]   valid_vec,
    output logic [ENTRIES-1:0]   match_vec,
    output tlb_ent_t             match_ent
);
    localparam int EW = $bits(tlb_ent_t);

    logic [ENTRIES-1:0][EW-1:0] ent_bits;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_ent_t ent_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (inv_all) begin
                ent_q.valid <= 1'b0;
            end else if (inv_one && ent_q.tag == inv_tag) begin
                ent_q.valid <= 1'b0;
            end else if (wr_go && wr_idx == IDX_W'(i)) begin
                ent_q <= wr_ent;
            end
        end

        assign ent_bits[i]  = ent_q;
        assign valid_vec[i] = ent_q.valid;
        assign match_vec[i] = ent_q.valid
                           && ent_q.tag[INV_W-1 -: VPN_W] == lk_vpn
                           && (ent_q.shared || ent_q.asid == lk_asid);
    end

    always_comb begin
        logic [EW-1:0] acc;
        acc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) acc = acc | ent_bits[i];
        end
        match_ent = tlb_ent_t'(acc);
    end
endmodule

// File: rtl/dtlb_victim_pick.sv
module dtlb_victim_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   slot
);
    logic [IDX_W-1:0] rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_comb begin
        slot = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) slot = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dtlb_access_check.sv
module dtlb_access_check
    import dtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_we,
    input  logic [MAP_W-1:0] map_wdata,
    input  logic [GRP_W-1:0] grp,
    input  logic             page_wr,
    input  logic             dirty,
    input  logic             is_write,
    output logic             deny,
    output logic             trap
);
    logic [MAP_W-1:0] map_q;
    grp_mode_e        mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= {GROUPS{GA_PAGE}};
        end else if (map_we) begin
            map_q <= map_wdata;
        end
    end

    assign mode = grp_mode_e'(map_q[2 * grp +: 2]);

    always_comb begin
        unique case (mode)
            GA_NONE:           deny = 1'b1;
            GA_PAGE:           deny = is_write && !page_wr;
            GA_FULL, GA_FULLX: deny = 1'b0;
        endcase
        trap = is_write && !dirty;
    end
endmodule

// File: rtl/dtlb_fa.sv
module dtlb_fa
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [31:0]       lk_ea,
    input  logic [3:0]        lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_err,
    output logic [31:0]       lk_pa,
    input  logic              fill_en,
    input  logic [31:0]       fill_ea,
    input  logic [3:0]        fill_asid,
    input  logic              fill_shared,
    input  logic [3:0]        fill_grp,
    input  logic [19:0]       fill_ppn,
    input  logic              fill_page_wr,
    input  logic              fill_dirty,
    input  logic              inv_one,
    input  logic              inv_all,
    input  logic [31:0]       inv_ea,
    input  logic              map_we,
    input  logic [31:0]       map_wdata,
    output logic              refill_pending
);
    localparam int IDX_W = $clog2(ENTRIES);

    fill_state_e        state_q, state_d;
    logic               fill_go;
    logic [IDX_W-1:0]   fill_slot;
    tlb_ent_t           new_ent;
    tlb_ent_t           match_ent;
    logic [ENTRIES-1:0] valid_vec, match_vec;
    logic               any_match, deny, trap, look_miss;

    assign fill_go = fill_en && !inv_one && !inv_all;

    always_comb begin
        new_ent         = '0;
        new_ent.valid   = 1'b1;
        new_ent.tag     = fill_ea[VA_W-1 -: INV_W];
        new_ent.asid    = fill_asid;
        new_ent.shared  = fill_shared;
        new_ent.grp     = fill_grp;
        new_ent.ppn     = fill_ppn;
        new_ent.page_wr = fill_page_wr;
        new_ent.dirty   = fill_dirty;
    end

    dtlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (fill_go),
        .wr_idx    (fill_slot),
        .wr_ent    (new_ent),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_tag   (inv_ea[VA_W-1 -: INV_W]),
        .lk_vpn    (lk_ea[VA_W-1:PG_OFF]),
        .lk_asid   (lk_asid),
        .valid_vec (valid_vec),
        .match_vec (match_vec),
        .match_ent (match_ent)
    );

    dtlb_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .advance   (fill_go),
        .slot      (fill_slot)
    );

    dtlb_access_check u_perm (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (map_we),
        .map_wdata (map_wdata),
        .grp       (match_ent.grp),
        .page_wr   (match_ent.page_wr),
        .dirty     (match_ent.dirty),
        .is_write  (lk_write),
        .deny      (deny),
        .trap      (trap)
    );

    assign any_match = |match_vec;
    assign look_miss = lk_req && !any_match;

    // lookup result, same cycle as the request
    always_comb begin
        lk_miss = look_miss;
        lk_hit  = lk_req && any_match && !deny && !trap;
        lk_err  = lk_req && any_match && (deny || trap);
        lk_pa   = lk_hit ? {match_ent.ppn, lk_ea[PG_OFF-1:0]} : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (look_miss) state_d = ST_AWAIT_FILL;
            end
            ST_AWAIT_FILL: begin
                if (!look_miss && fill_go) state_d = ST_RUN;
            end
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:        refill_pending = 1'b0;
            ST_AWAIT_FILL: refill_pending = 1'b1;
        endcase
    end
endmodule

// File: rtl/dtlb_fa_checker.sv
module dtlb_fa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic [31:0] lk_ea,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic        lk_err,
    input logic [31:0] lk_pa,
    input logic        fill_en,
    input logic        inv_one,
    input logic        inv_all,
    input logic        refill_pending
);
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_err}));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_err));

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[11:0] == lk_ea[11:0]);

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit && !lk_err);

    p_miss_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_miss |=> refill_pending);

    p_fill_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !inv_one && !inv_all && !(lk_req && lk_miss) |=> !refill_pending);
endmodule

bind dtlb_fa dtlb_fa_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_req         (lk_req),
    .lk_ea          (lk_ea),
    .lk_hit         (lk_hit),
    .lk_miss        (lk_miss),
    .lk_err         (lk_err),
    .lk_pa          (lk_pa),
    .fill_en        (fill_en),
    .inv_one        (inv_one),
    .inv_all        (inv_all),
    .refill_pending (refill_pending)
);

// File: tb/dtlb_fa_bench.sv
module dtlb_fa_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req, lk_write, lk_hit, lk_miss, lk_err;
    logic [31:0] lk_ea, lk_pa;
    logic [3:0]  lk_asid;
    logic        fill_en, fill_shared, fill_page_wr, fill_dirty;
    logic [31:0] fill_ea;
    logic [3:0]  fill_asid, fill_grp;
    logic [19:0] fill_ppn;
    logic        inv_one, inv_all, map_we, refill_pending;
    logic [31:0] inv_ea, map_wdata;

    dtlb_fa u_dtlb_fa (.*);

    always #2 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R12";

    // reference model
    bit          m_valid [8];
    bit [21:0]   m_tag   [8];
    bit [3:0]    m_asid  [8];
    bit          m_shr   [8];
    bit [3:0]    m_grp   [8];
    bit [19:0]   m_ppn   [8];
    bit          m_pwr   [8];
    bit          m_dirty [8];
    int          m_rr;
    bit [31:0]   m_map;
    bit          m_pend;
    bit          e_hit, e_miss, e_err;
    bit [31:0]   e_pa;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    task automatic cmp(string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h exp %h", cur_req, what, got, exp);
        end
    endtask

    task automatic model_look();
        int idx = -1;
        bit [1:0] mode;
        e_hit = 0; e_miss = 0; e_err = 0; e_pa = 0;
        if (!lk_req) return;
        for (int i = 0; i < 8; i++)
            if (m_valid[i] && m_tag[i][21:2] == lk_ea[31:12] &&
                (m_shr[i] || m_asid[i] == lk_asid)) idx = i;
        if (idx < 0) begin
            e_miss = 1;
            return;
        end
        mode = m_map[2*m_grp[idx] +: 2];
        if (mode == 2'b00) e_err = 1;
        else if (mode == 2'b01 && lk_write && !m_pwr[idx]) e_err = 1;
        else if (lk_write && !m_dirty[idx]) e_err = 1;
        else begin
            e_hit = 1;
            e_pa  = {m_ppn[idx], lk_ea[11:0]};
        end
    endtask

    task automatic model_step();
        bit go = fill_en && !inv_one && !inv_all;
        int slot = m_rr;
        if (inv_all) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 0;
        end else if (inv_one) begin
            for (int i = 0; i < 8; i++)
                if (m_tag[i] == inv_ea[31:10]) m_valid[i] = 0;
        end else if (go) begin
            for (int i = 7; i >= 0; i--) if (!m_valid[i]) slot = i;
            m_valid[slot] = 1;
            m_tag[slot] = fill_ea[31:10];
            m_asid[slot] = fill_asid;
            m_shr[slot] = fill_shared;
            m_grp[slot] = fill_grp;
            m_ppn[slot] = fill_ppn;
            m_pwr[slot] = fill_page_wr;
            m_dirty[slot] = fill_dirty;
            m_rr = (m_rr + 1) % 8;
        end
        if (map_we) m_map = map_wdata;
        if (e_miss) m_pend = 1;
        else if (go) m_pend = 0;
    endtask

    // inputs were set at the falling edge; compare, advance model, wait
    task automatic tick();
        #1;
        model_look();
        cmp("hit", 32'(lk_hit), 32'(e_hit));
        cmp("miss", 32'(lk_miss), 32'(e_miss));
        cmp("err", 32'(lk_err), 32'(e_err));
        cmp("pa", lk_pa, e_pa);
        cmp("pending", 32'(refill_pending), 32'(m_pend));
        model_step();
        @(negedge clk);
    endtask

    task automatic clear_in();
        lk_req = 0; lk_ea = 0; lk_asid = 0; lk_write = 0;
        fill_en = 0; fill_ea = 0; fill_asid = 0; fill_shared = 0;
        fill_grp = 0; fill_ppn = 0; fill_page_wr = 0; fill_dirty = 0;
        inv_one = 0; inv_all = 0; inv_ea = 0; map_we = 0; map_wdata = 0;
    endtask

    task automatic set_fill(bit [31:0] ea, bit [3:0] asid, bit shr, bit [3:0] grp,
                            bit [19:0] ppn, bit pwr, bit dirty);
        fill_en = 1; fill_ea = ea; fill_asid = asid; fill_shared = shr;
        fill_grp = grp; fill_ppn = ppn; fill_page_wr = pwr; fill_dirty = dirty;
    endtask

    task automatic do_fill(bit [31:0] ea, bit [3:0] asid, bit shr, bit [3:0] grp,
                           bit [19:0] ppn, bit pwr, bit dirty);
        clear_in();
        set_fill(ea, asid, shr, grp, ppn, pwr, dirty);
        tick();
    endtask

    task automatic do_look(bit [31:0] ea, bit [3:0] asid, bit wr);
        clear_in();
        lk_req = 1; lk_ea = ea; lk_asid = asid; lk_write = wr;
        tick();
    endtask

    task automatic do_inv(bit one, bit all, bit [31:0] ea);
        clear_in();
        inv_one = one; inv_all = all; inv_ea = ea;
        tick();
    endtask

    task automatic do_map(bit [31:0] w);
        clear_in();
        map_we = 1; map_wdata = w;
        tick();
    endtask

    initial begin
        bit [19:0] vpn;
        bit [31:0] r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_valid[i] = 0;
        m_rr = 0; m_map = 32'h5555_5555; m_pend = 0;
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        cur_req = "R12";
        do_look(32'h1234_5000, 4'd1, 0);
        do_look(32'h0000_0000, 4'd0, 1);

        cur_req = "R11";
        do_fill({20'h12345, 12'h000}, 4'd1, 0, 4'd0, 20'hABCDE, 1, 1);
        clear_in();
        set_fill({20'h22222, 12'h000}, 4'd1, 0, 4'd0, 20'h00222, 1, 1);
        lk_req = 1; lk_ea = 32'h9999_9000; lk_asid = 4'd1;
        tick();

        cur_req = "R1";
        do_look(32'h1234_5ABC, 4'd1, 0);
        do_look(32'h1234_5123, 4'd1, 1);

        cur_req = "R2";
        do_look(32'h1234_5ABC, 4'd2, 0);
        do_fill({20'h23456, 12'h000}, 4'd3, 1, 4'd0, 20'h55555, 1, 1);
        do_look(32'h2345_6FFF, 4'd7, 0);

        cur_req = "R8";
        do_fill({20'h34567, 12'h000}, 4'd1, 0, 4'd0, 20'h11111, 1, 0);
        do_look(32'h3456_7010, 4'd1, 1);
        do_look(32'h3456_7010, 4'd1, 0);

        cur_req = "R10";
        do_fill({20'h45678, 12'h000}, 4'd1, 0, 4'd2, 20'h22222, 0, 1);
        do_look(32'h4567_8004, 4'd1, 1);
        do_map(32'h5555_5565);
        do_look(32'h4567_8004, 4'd1, 1);

        cur_req = "R9";
        do_map(32'h5555_5554);
        do_look(32'h1234_5ABC, 4'd1, 0);
        do_map(32'h5555_5555);
        do_look(32'h1234_5ABC, 4'd1, 0);

        cur_req = "R5";
        do_fill({20'h56789, 2'b01, 10'h000}, 4'd4, 0, 4'd0, 20'h33333, 1, 1);
        do_inv(1, 0, {20'h56789, 2'b00, 10'h3FF});
        do_look(32'h5678_9400, 4'd4, 0);
        do_inv(1, 0, {20'h56789, 2'b01, 10'h155});
        do_look(32'h5678_9400, 4'd4, 0);

        cur_req = "R6";
        do_inv(0, 1, 32'h0);
        do_look(32'h1234_5ABC, 4'd1, 0);
        do_look(32'h2345_6FFF, 4'd3, 0);

        cur_req = "R7";
        clear_in();
        set_fill({20'h67890, 12'h000}, 4'd1, 0, 4'd0, 20'h44444, 1, 1);
        inv_all = 1;
        tick();
        do_look(32'h6789_0000, 4'd1, 0);
        clear_in();
        set_fill({20'h67891, 12'h000}, 4'd1, 0, 4'd0, 20'h44445, 1, 1);
        inv_one = 1; inv_ea = 32'hFFFF_F000;
        tick();
        do_look(32'h6789_1000, 4'd1, 0);

        cur_req = "R4";
        for (int i = 0; i < 9; i++)
            do_fill({20'h40000 + 20'(i), 12'h000}, 4'd1, 0, 4'd0, 20'h70000 + 20'(i), 1, 1);
        for (int i = 0; i < 9; i++)
            do_look({20'h40000 + 20'(i), 12'h008}, 4'd1, 0);

        cur_req = "R1/R3 random";
        for (int n = 0; n < 4000; n++) begin
            clear_in();
            r = $urandom();
            if ($urandom() % 10 < 7) begin
                vpn = 20'hC3A00 + 20'($urandom() % 12);
                lk_req = 1; lk_ea = {vpn, 12'($urandom())};
                lk_asid = 4'($urandom() % 4); lk_write = r[0];
            end
            if (r[7:4] < 3) begin
                vpn = 20'hC3A00 + 20'($urandom() % 12);
                set_fill({vpn, vpn[1:0], 10'($urandom())}, 4'($urandom() % 4),
                         r[8], 4'($urandom()), 20'($urandom()), r[9], r[10]);
                for (int i = 0; i < 8; i++)
                    if (m_valid[i] && m_tag[i][21:2] == vpn) begin
                        inv_one = 1;
                        inv_ea = {m_tag[i], 10'($urandom())};
                    end
            end else if (r[7:4] == 3) begin
                vpn = 20'hC3A00 + 20'($urandom() % 12);
                inv_one = 1; inv_ea = {vpn, vpn[1:0], 10'($urandom())};
            end
            if (r[15:11] == 0) inv_all = 1;
            if (r[20:16] == 0) begin
                map_we = 1; map_wdata = $urandom() | 32'h5555_5555;
            end
            tick();
        end

        summary();
    end
endmodule